// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide programming and arbitration core of one eight-line interrupt controller. Software reaches it through a one-bit address with single-cycle write and read strobes. It decodes the start-up word sequence, the command words that end service or move the rotating priority base, the control word that picks the readback register and arms a poll, and the mask writes. It keeps the pending, in-service and mask registers, and the priority resolver built around them decides which line is raised to the processor.

Request lines are captured on their rising edges into the pending register. The processor takes a request with an acknowledge strobe, which returns the vector for the winning line. A poll read does the same job through the register port. A single-cycle notice tells a neighbouring controller when the resolution may have changed, so that a cascaded pair can be kept consistent outside this block.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset the mask, pending and in-service registers, the priority base, the vector base, the readback select, the poll flag, special mask, both auto-end modes and the start-up step are zero, so `int_req` is low and both reads return 0.
- R2: A write to address 0 with bit 4 set clears all of that state and drops `int_req` at the next edge. It records bit 0 as "fourth word expected" and enters start-up step 1.
- R3: In step 1 an address-1 write stores bits 7:3 as the vector base and moves to step 2. Step 2 moves to step 3 when a fourth word is expected and to normal mode otherwise. In step 3 bit 1 enables auto-end and bit 4 enables special fully nested mode, and the block returns to normal mode.
- R4: In normal mode an address-1 write loads the mask, which is read back at address 1. A masked line never raises `int_req`. `cascade_upd` is high in the cycle of that write.
- R5: An address-0 write with bit 4 clear and bit 3 set is a control word. If bit 1 is set, bit 0 picks the address-0 readback (1 = in-service, 0 = pending). If bit 1 is clear, the selection is kept.
- R6: In a control word with bit 6 set, bit 5 becomes `special_mask_on`. With bit 6 clear, `special_mask_on` keeps its value.
- R7: A rising edge on `irq_lines[n]` sets pending bit n. Priority order starts at the base line and wraps upward. `int_req` is high when the best unmasked pending line ranks above the best in-service line.
- R8: `inta` moves the winning line from pending to in-service. `vector` returns the vector base in bits 7:3 and the line in bits 2:0, or line 7 when nothing wins.
- R9: Command 1 (address 0, bits 7:5 = 1, bits 4:3 = 0) clears the highest-ranked in-service bit. Command 5 does the same and also sets the base to that line + 1. Both raise `cascade_upd`.
- R10: Command 3 clears the in-service bit named by bits 2:0. Command 7 does the same and also sets the base to the named line + 1.
- R11: Command 6 sets the base to (bits 2:0 + 1) mod 8. Command 2 changes nothing.
- R12: With auto-end enabled, `inta` leaves no in-service bit set. Command 4 enables rotation on auto-end, which sets the base to the acknowledged line + 1. Command 0 disables it.
- R13: A read while poll is armed returns the winning line (or 7 if none wins) in bits 2:0 with zeros above, clears that line's pending and in-service bits, and disarms poll. Poll applies at either address.
- R14: In special fully nested mode, an in-service cascade line (line 2) does not block a new request on that same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Single-cycle register write strobe |
| rd_stb | input | 1 | Single-cycle register read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_stb` |
| irq_lines | input | 8 | Request lines, edge captured |
| inta | input | 1 | Single-cycle interrupt acknowledge |
| vector | output | 8 | Vector for the current winner, taken with `inta` |
| int_req | output | 1 | Interrupt request to the processor |
| special_mask_on | output | 1 | Special mask mode flag |
| cascade_upd | output | 1 | Resolution may have changed (mask, command or poll access) |

## Verification
All state is registered and the outputs are decoded combinationally from it. `rdata`, `vector` and `cascade_upd` are therefore due in the same cycle as their strobe, and `int_req` and every register read reflect a write or a request edge one clock later. The bench drives strobes at the falling edge and samples 1 ns later. It reads back a write's effect only in a later cycle, and it checks `int_req` after the edge that follows the stimulus. Expected vectors are worked out from the rotation base and the masks, and each case is built so that a wrong base would pick a different line.

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq #(
  parameter int CASCADE_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_lines,
  input  logic       inta,
  output logic [7:0] vector,
  output logic       int_req,
  output logic       special_mask_on,
  output logic       cascade_upd
);

  logic [7:0] imr, irr, isr, last;
  logic [2:0] base;
  logic [4:0] vbase;
  logic [1:0] step;
  logic       ic4, sel, poll, smm, aeoi, rot, sfnm;

  logic [7:0] n_imr, n_irr, n_isr;
  logic [2:0] n_base;
  logic [4:0] n_vbase;
  logic [1:0] n_step;
  logic       n_ic4, n_sel, n_poll, n_smm, n_aeoi, n_rot, n_sfnm;

  function automatic logic [3:0] rank(input logic [7:0] m, input logic [2:0] b);
    logic [3:0] r;
    r = 4'd8;
    for (int p = 7; p >= 0; p--)
      if (m[3'(p) + b]) r = 4'(p);
    return r;
  endfunction

  logic [3:0] req_p, cur_p, top_p;
  logic [2:0] win, top_line;
  logic       has_win;
  logic [7:0] svc;
  logic [2:0] cmd;
  logic       is_init, is_ctl, is_cmd;

  assign svc      = isr & ~(sfnm ? 8'(1 << CASCADE_LINE) : 8'd0);
  assign req_p    = rank(irr & ~imr, base);
  assign cur_p    = rank(svc, base);
  assign has_win  = req_p < cur_p;
  assign win      = req_p[2:0] + base;
  assign top_p    = rank(isr, base);
  assign top_line = top_p[2:0] + base;

  assign cmd     = wdata[7:5];
  assign is_init = wr_stb && !addr && wdata[4];
  assign is_ctl  = wr_stb && !addr && !wdata[4] && wdata[3];
  assign is_cmd  = wr_stb && !addr && !wdata[4] && !wdata[3];

  assign int_req         = has_win;
  assign vector          = {vbase, has_win ? win : 3'd7};
  assign special_mask_on = smm;
  assign rdata = !rd_stb ? 8'd0 :
                 poll    ? {5'd0, has_win ? win : 3'd7} :
                 addr    ? imr :
                 sel     ? isr : irr;
  assign cascade_upd = (wr_stb && addr && step == 2'd0) ||
                       (is_cmd && (cmd == 3'd1 || cmd == 3'd3 || cmd == 3'd5 ||
                                   cmd == 3'd6 || cmd == 3'd7)) ||
                       (rd_stb && poll);

  always_comb begin
    n_imr = imr;  n_irr = irr | (irq_lines & ~last);  n_isr = isr;
    n_base = base;  n_vbase = vbase;  n_step = step;  n_ic4 = ic4;
    n_sel = sel;  n_poll = poll;  n_smm = smm;  n_aeoi = aeoi;
    n_rot = rot;  n_sfnm = sfnm;

    if (inta && has_win) begin
      n_isr[win] = 1'b1;
      n_irr[win] = 1'b0;
      if (aeoi) begin
        if (rot) n_base = win + 3'd1;
        n_isr[win] = 1'b0;
      end
    end

    if (rd_stb && poll) begin
      if (has_win) begin
        n_irr[win] = 1'b0;
        n_isr[win] = 1'b0;
      end
      n_poll = 1'b0;
    end

    if (is_init) begin
      n_imr = '0;  n_irr = '0;  n_isr = '0;  n_base = '0;  n_vbase = '0;
      n_sel = 1'b0;  n_poll = 1'b0;  n_smm = 1'b0;  n_aeoi = 1'b0;
      n_rot = 1'b0;  n_sfnm = 1'b0;
      n_step = 2'd1;
      n_ic4 = wdata[0];
    end else if (is_ctl) begin
      if (wdata[2]) n_poll = 1'b1;
      if (wdata[1]) n_sel = wdata[0];
      if (wdata[6]) n_smm = wdata[5];
    end else if (is_cmd) begin
      case (cmd)
        3'd0, 3'd4: n_rot = cmd[2];
        3'd1, 3'd5: if (top_p != 4'd8) begin
          n_isr[top_line] = 1'b0;
          if (cmd[2]) n_base = top_line + 3'd1;
        end
        3'd3: n_isr[wdata[2:0]] = 1'b0;
        3'd6: n_base = wdata[2:0] + 3'd1;
        3'd7: begin
          n_isr[wdata[2:0]] = 1'b0;
          n_base = wdata[2:0] + 3'd1;
        end
        default: ;
      endcase
    end else if (wr_stb && addr) begin
      case (step)
        2'd0: n_imr = wdata;
        2'd1: begin n_vbase = wdata[7:3]; n_step = 2'd2; end
        2'd2: n_step = ic4 ? 2'd3 : 2'd0;
        default: begin
          n_sfnm = wdata[4];
          n_aeoi = wdata[1];
          n_step = 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr <= '0;  irr <= '0;  isr <= '0;  last <= '0;
      base <= '0;  vbase <= '0;  step <= '0;  ic4 <= 1'b0;
      sel <= 1'b0;  poll <= 1'b0;  smm <= 1'b0;  aeoi <= 1'b0;
      rot <= 1'b0;  sfnm <= 1'b0;
    end else begin
      imr <= n_imr;  irr <= n_irr;  isr <= n_isr;  last <= irq_lines;
      base <= n_base;  vbase <= n_vbase;  step <= n_step;  ic4 <= n_ic4;
      sel <= n_sel;  poll <= n_poll;  smm <= n_smm;  aeoi <= n_aeoi;
      rot <= n_rot;  sfnm <= n_sfnm;
    end
  end

  // R2
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_init |=> (step == 2'd1 && isr == 8'd0 && !int_req));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr && step == 2'd0) |=> imr == $past(wdata));

  // R7
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr & ~imr) != 8'd0);

  // R9
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && cmd == 3'd1 && isr != 8'd0 && !inta && !rd_stb)
      |=> $countones(isr) == $countones($past(isr)) - 1);

  // R13
  poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && poll && !wr_stb) |=> !poll);

  // R13
  poll_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && poll) |-> rdata[7:3] == 5'd0);

endmodule

// File: tb/test_irq_cmd_seq.sv
`timescale 1ns/1ps
module test_irq_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 1'b0, rd_stb = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = 8'd0, irq_lines = 8'd0;
  logic [7:0] rdata, vector;
  logic int_req, special_mask_on, cascade_upd;
  int ncheck = 0, nerr = 0;
  logic last_cu;
  logic [7:0] v;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_cmd_seq i_irq_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines), .inta(inta),
    .vector(vector), .int_req(int_req), .special_mask_on(special_mask_on),
    .cascade_upd(cascade_upd)
  );

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    ncheck++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
    #1 last_cu = cascade_upd;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_stb = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic ack(output logic [7:0] d);
    @(negedge clk); inta = 1'b1;
    #1 d = vector;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); irq_lines[n] = 1'b1;
    @(negedge clk); irq_lines[n] = 1'b0;
  endtask

  task automatic req_is(string r, logic exp);
    #1 chk(r, {7'd0, int_req}, {7'd0, exp});
  endtask

  task automatic setup(logic [7:0] vb, logic four, logic [7:0] w4);
    wr(0, 8'h10 | {7'd0, four});
    wr(1, vb);
    wr(1, 8'h00);
    if (four) wr(1, w4);
  endtask

  task automatic t_reset;
    rd(1, v); chk("R1 mask", v, 8'h00);
    rd(0, v); chk("R1 pending", v, 8'h00);
    req_is("R1 int_req", 1'b0);
    chk("R1 special mask", {7'd0, special_mask_on}, 8'h00);
  endtask

  task automatic t_startup;
    setup(8'h47, 1'b1, 8'h00);
    wr(1, 8'hF0); chk("R4 cascade_upd", {7'd0, last_cu}, 8'h01);
    rd(1, v); chk("R4 mask read", v, 8'hF0);
    ack(v); chk("R8 spurious vector", v, 8'h47);
    setup(8'h20, 1'b0, 8'h00);
    wr(1, 8'h81);
    rd(1, v); chk("R3 no fourth word", v, 8'h81);
    ack(v); chk("R3 vector base", v, 8'h27);
  endtask

  task automatic t_pending;
    setup(8'h40, 1'b1, 8'h00);
    pulse(5); pulse(3);
    rd(0, v); chk("R7 pending", v, 8'h28);
    req_is("R7 request", 1'b1);
    ack(v); chk("R8 vector", v, 8'h43);
    wr(0, 8'h0B); rd(0, v); chk("R5 select in-service", v, 8'h08);
    wr(0, 8'h0A); rd(0, v); chk("R5 select pending", v, 8'h20);
    req_is("R7 blocked by in-service", 1'b0);
    wr(0, 8'h20); chk("R9 cascade_upd", {7'd0, last_cu}, 8'h01);
    req_is("R9 eoi reopens", 1'b1);
    wr(1, 8'h20); req_is("R4 masked line", 1'b0);
    wr(1, 8'h00);
    ack(v); chk("R8 second vector", v, 8'h45);
    wr(0, 8'h0B); wr(0, 8'h08);
    rd(0, v); chk("R5 select kept", v, 8'h20);
    wr(0, 8'h65); rd(0, v); chk("R10 specific eoi", v, 8'h00);
  endtask

  task automatic t_rotate;
    setup(8'h80, 1'b0, 8'h00);
    pulse(1); pulse(6);
    wr(0, 8'hC5);
    ack(v); chk("R11 set base", v, 8'h86);
    wr(0, 8'h0B); wr(0, 8'h40);
    rd(0, v); chk("R11 command 2 idle", v, 8'h40);
    wr(0, 8'hA0); rd(0, v); chk("R9 rotating eoi clears", v, 8'h00);
    pulse(7);
    ack(v); chk("R9 rotating eoi base", v, 8'h87);
    wr(0, 8'h67); rd(0, v); chk("R10 specific clear", v, 8'h00);
    wr(0, 8'hE3); pulse(5);
    ack(v); chk("R10 specific rotate base", v, 8'h85);
  endtask

  task automatic t_poll;
    setup(8'h10, 1'b0, 8'h00);
    pulse(2); pulse(6);
    wr(0, 8'h0C); rd(0, v); chk("R13 poll winner", v, 8'h02);
    rd(0, v); chk("R13 poll disarmed and cleared", v, 8'h40);
    wr(0, 8'h0C); rd(1, v); chk("R13 poll at address 1", v, 8'h06);
    wr(0, 8'h0C); rd(0, v); chk("R13 poll none", v, 8'h07);
  endtask

  task automatic t_smask;
    wr(0, 8'h68); #1 chk("R6 set", {7'd0, special_mask_on}, 8'h01);
    wr(0, 8'h28); #1 chk("R6 kept", {7'd0, special_mask_on}, 8'h01);
    wr(0, 8'h48); #1 chk("R6 clear", {7'd0, special_mask_on}, 8'h00);
  endtask

  task automatic t_autoend;
    setup(8'h30, 1'b1, 8'h02);
    wr(0, 8'h80);
    pulse(4);
    ack(v); chk("R12 vector", v, 8'h34);
    wr(0, 8'h0B); rd(0, v); chk("R12 no in-service", v, 8'h00);
    pulse(0); pulse(5);
    ack(v); chk("R12 rotated base", v, 8'h35);
    wr(0, 8'h00);
    pulse(7);
    ack(v); chk("R12 rotation off", v, 8'h37);
    pulse(6);
    ack(v); chk("R12 base held", v, 8'h36);
  endtask

  task automatic t_nested;
    setup(8'h50, 1'b1, 8'h10);
    pulse(2); ack(v); chk("R14 vector", v, 8'h52);
    pulse(2); req_is("R14 nested request", 1'b1);
    setup(8'h50, 1'b1, 8'h00);
    pulse(2); ack(v);
    pulse(2); req_is("R14 plain blocks", 1'b0);
  endtask

  task automatic t_restart;
    wr(1, 8'h80);
    pulse(1); req_is("R2 before", 1'b1);
    wr(0, 8'h11); req_is("R2 drop", 1'b0);
    rd(0, v); chk("R2 pending cleared", v, 8'h00);
    wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00);
    rd(1, v); chk("R2 mask cleared", v, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nerr++; ncheck++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, ncheck);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_startup;
    t_pending;
    t_rotate;
    t_poll;
    t_smask;
    t_autoend;
    t_nested;
    t_restart;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, ncheck);
    $finish;
  end
endmodule